// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O controller

This block is a bus-attached general-purpose I/O peripheral for up to 32 pins. Software reaches it through a simple APB-style register port with no wait states. Each pin has a control word that enables its input path, its output path and its output driver, and arms an event detector. The detector can be set to one of five trigger kinds: high level, low level, rising edge, falling edge or either edge. Shared words hold the pending-event flags, the synchronized pad levels and the output data.

Pad levels first pass through a two-flop synchronizer. Edge kinds compare the synchronized level with the level one cycle earlier. A detected event latches a pending flag, and software clears that flag by writing a one to its position. All pending flags are ORed into one interrupt line. The pin count is a parameter from 1 to 32, checked when the design is elaborated.

Top module: `pin_io_ctrl`

## Requirements
- R1: The control word of pin i is at byte offset 4*i. Its fields are: bit 0 output enable, bit 1 input enable, bit 2 driver enable, bit 3 event enable, bits 7:5 trigger kind. Bits 7:5 and 3:0 read back as written. Bit 4 and bits 31:8 read as zero.
- R2: `pad_oe[i]` is 1 exactly when both bit 0 and bit 2 of the control word of pin i are 1. The output word at offset 0x88 drives `pad_out` and reads back as written.
- R3: The input word at offset 0x84 returns each pad level after two clock edges of synchronization.
- R4: A pin sets its pending flag only when both bit 1 and bit 3 of its control word are 1.
- R5: Trigger kind 000 sets the flag while the synchronized level is high. Trigger kind 001 sets it while the level is low.
- R6: Trigger kind 010 fires on a rise, 011 on a fall and 100 on either edge. Codes 101 to 111 never set a flag.
- R7: The pending word is at offset 0x80, one bit per pin. Writing 1 to a bit clears that flag. Writing 0 to a bit leaves it unchanged.
- R8: A level trigger whose level persists sets its flag again in the same cycle as a clear, so the flag reads 1 after the clear.
- R9: `irq` is 1 exactly when at least one pending flag is 1.
- R10: Reads of any offset other than the control words of implemented pins, 0x80, 0x84 and 0x88 return zero.
- R11: After reset, all control words, the output word and the pending word are zero, `pad_oe` is zero and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Output data for each pad |
| pad_oe | output | NPINS | Driver enable for each pad |
| irq | output | 1 | Combined pending-event interrupt |

## Verification
The assertions check four rules on every cycle. A pending flag only rises on a pin that has both its input path and its event detector enabled. A flag stays set unless a one is written to its position. Control and output writes reach `pad_oe` and `pad_out` on the next cycle. A rising `irq` always follows an armed pin. Only the bench's scenarios can show that each trigger kind fires on its own pattern and stays silent on the opposite one, and that a persisting level re-pends right after a clear while an edge does not. The same holds for the reserved codes staying quiet, for the synchronized input word, and for unmapped offsets reading zero.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

   localparam int unsigned MAX_PINS = 32;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned ADDR_W   = 8;

   localparam logic [ADDR_W-1:0] OFS_PEND = 8'h80;
   localparam logic [ADDR_W-1:0] OFS_LVL  = 8'h84;
   localparam logic [ADDR_W-1:0] OFS_DOUT = 8'h88;

   typedef enum logic [2:0] {
      TRIG_HIGH = 3'd0,
      TRIG_LOW  = 3'd1,
      TRIG_RISE = 3'd2,
      TRIG_FALL = 3'd3,
      TRIG_ANY  = 3'd4
   } trig_e;

   // bit order matches the control word: [7:5] trig, [4] spare, [3] ev, [2] drv, [1] in, [0] out
   typedef struct packed {
      logic [2:0] trig;
      logic       spare;
      logic       ev_en;
      logic       drv_en;
      logic       in_en;
      logic       out_en;
   } pin_cfg_t;

endpackage

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_io_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pin_io_detect.sv
module pin_io_detect
   import pin_io_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pin_cfg_t [NPINS-1:0] cfg,
   input  logic [NPINS-1:0]     lvl,
   output logic [NPINS-1:0]     hit
);

   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar g = 0; g < int'(NPINS); g++) begin : g_pin
         logic rise, fall, cond;
         assign rise = lvl[g] & ~prev_q[g];
         assign fall = ~lvl[g] & prev_q[g];

         always_comb begin
            case (cfg[g].trig)
               TRIG_HIGH: cond = lvl[g];
               TRIG_LOW:  cond = ~lvl[g];
               TRIG_RISE: cond = rise;
               TRIG_FALL: cond = fall;
               TRIG_ANY:  cond = rise | fall;
               default:   cond = 1'b0;
            endcase
         end

         assign hit[g] = cond & cfg[g].in_en & cfg[g].ev_en;
      end
   endgenerate

endmodule

// File: rtl/pin_io_regs.sv
module pin_io_regs
   import pin_io_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [WORD_W-1:0]    pwdata,
   output logic [WORD_W-1:0]    prdata,
   input  logic [NPINS-1:0]     lvl,
   input  logic [NPINS-1:0]     hit,
   output pin_cfg_t [NPINS-1:0] cfg_q,
   output logic [NPINS-1:0]     dout_q,
   output logic [NPINS-1:0]     pend_q
);

   localparam int unsigned IDX_W = 5;

   logic             wr_en;
   logic             cfg_hit;
   logic [IDX_W-1:0] idx;
   logic [NPINS-1:0] clr;

   assign wr_en   = psel & penable & pwrite;
   assign idx     = paddr[IDX_W+1:2];
   assign cfg_hit = ~paddr[ADDR_W-1] && (int'(idx) < int'(NPINS));

   generate
      for (genvar g = 0; g < int'(NPINS); g++) begin : g_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[g] <= '0;
            else if (wr_en && cfg_hit && idx == IDX_W'(g))
               cfg_q[g] <= {pwdata[7:5], 1'b0, pwdata[3:0]};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dout_q <= '0;
      else if (wr_en && paddr == OFS_DOUT) dout_q <= pwdata[NPINS-1:0];
   end

   assign clr = (wr_en && paddr == OFS_PEND) ? pwdata[NPINS-1:0] : '0;

   // a fresh event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | hit;
   end

   always_comb begin
      prdata = '0;
      if (cfg_hit) begin
         prdata[7:0] = cfg_q[idx];
      end else begin
         case (paddr)
            OFS_PEND: prdata[NPINS-1:0] = pend_q;
            OFS_LVL:  prdata[NPINS-1:0] = lvl;
            OFS_DOUT: prdata[NPINS-1:0] = dout_q;
            default:  prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
   import pin_io_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [7:0]        paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);

   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
         $error("pin_io_ctrl: NPINS must lie in 1..32");
      end
   endgenerate

   pin_cfg_t [NPINS-1:0] cfg_vec;
   logic [NPINS-1:0]     lvl_vec;
   logic [NPINS-1:0]     hit_vec;
   logic [NPINS-1:0]     pend_vec;

   pin_io_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl_vec)
   );

   pin_io_detect #(.NPINS(NPINS)) detect_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (cfg_vec),
      .lvl   (lvl_vec),
      .hit   (hit_vec)
   );

   pin_io_regs #(.NPINS(NPINS)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .prdata  (prdata),
      .lvl     (lvl_vec),
      .hit     (hit_vec),
      .cfg_q   (cfg_vec),
      .dout_q  (pad_out),
      .pend_q  (pend_vec)
   );

   generate
      for (genvar g = 0; g < int'(NPINS); g++) begin : g_oe
         assign pad_oe[g] = cfg_vec[g].out_en & cfg_vec[g].drv_en;
      end
   endgenerate

   assign irq = |pend_vec;

endmodule

// File: rtl/pin_io_chk.sv
module pin_io_chk #(
   parameter int unsigned NPINS = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               psel,
   input logic               penable,
   input logic               pwrite,
   input logic [7:0]         paddr,
   input logic [31:0]        pwdata,
   input logic [NPINS-1:0]   pad_out,
   input logic [NPINS-1:0]   pad_oe,
   input logic               irq,
   input logic [NPINS-1:0]   pend,
   input logic [NPINS*8-1:0] cfg_bits
);

   logic wr, wr_pend, wr_dout;
   logic [NPINS-1:0] armed;

   assign wr      = psel & penable & pwrite;
   assign wr_pend = wr && paddr == 8'h80;
   assign wr_dout = wr && paddr == 8'h88;

   generate
      for (genvar i = 0; i < int'(NPINS); i++) begin : g_pin
         logic wr_cfg;
         assign armed[i] = cfg_bits[i*8+1] & cfg_bits[i*8+3];
         assign wr_cfg   = wr && !paddr[7] && paddr[6:2] == 5'(i);

         // R4
         pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(armed[i]));

         // R7
         pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !(wr_pend && pwdata[i])) |=> pend[i]);

         // R2
         oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cfg && pwdata[0] && pwdata[2]) |=> pad_oe[i]);
      end
   endgenerate

   // R2
   dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dout |=> pad_out == $past(pwdata[NPINS-1:0]));

   // R9
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|armed));

endmodule

bind pin_io_ctrl pin_io_chk #(.NPINS(NPINS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .irq      (irq),
   .pend     (pend_vec),
   .cfg_bits (cfg_vec)
);

// File: tb/pin_io_ctrl_tb.sv
`timescale 1ns/1ps
module pin_io_ctrl_tb_top;

   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          psel, penable, pwrite;
   logic [7:0]    paddr;
   logic [31:0]   pwdata;
   logic [31:0]   prdata;
   logic [NP-1:0] pad_in, pad_out, pad_oe;
   logic          irq;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pin_io_ctrl #(.NPINS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // vector: [5:3] trigger kind, [2] start level, [1] end level, [0] expected flag
   localparam int NV = 11;
   localparam logic [5:0] VEC [NV] = '{
      {3'd0, 1'b0, 1'b1, 1'b1},   // R5 high level appears
      {3'd0, 1'b0, 1'b0, 1'b0},   // R5 stays low
      {3'd1, 1'b1, 1'b0, 1'b1},   // R5 low level appears
      {3'd1, 1'b1, 1'b1, 1'b0},   // R5 stays high
      {3'd2, 1'b0, 1'b1, 1'b1},   // R6 rise on rise
      {3'd2, 1'b1, 1'b0, 1'b0},   // R6 rise ignores fall
      {3'd3, 1'b1, 1'b0, 1'b1},   // R6 fall on fall
      {3'd3, 1'b0, 1'b1, 1'b0},   // R6 fall ignores rise
      {3'd4, 1'b0, 1'b1, 1'b1},   // R6 either, rise
      {3'd4, 1'b1, 1'b0, 1'b1},   // R6 either, fall
      {3'd5, 1'b0, 1'b1, 1'b0}    // R6 reserved code
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      paddr = '0; pwdata = '0; pad_in = '0;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R11 reset state
      chk("R11 pad_oe", pad_oe, '0);
      chk("R11 irq", {31'b0, irq}, 32'd0);
      chk("R11 pad_out", pad_out, '0);
      apb_rd(8'h00, rd); chk("R11 cfg0", rd, 32'h0);
      apb_rd(8'h7C, rd); chk("R11 cfg31", rd, 32'h0);
      apb_rd(8'h80, rd); chk("R11 pend", rd, 32'h0);
      apb_rd(8'h88, rd); chk("R11 dout", rd, 32'h0);

      // R1 field storage and masking
      apb_wr(8'h14, 32'hFFFF_FFFF);
      apb_rd(8'h14, rd); chk("R1 cfg5 readback", rd, 32'h0000_00EF);
      apb_rd(8'h18, rd); chk("R1 cfg6 untouched", rd, 32'h0);
      apb_wr(8'h14, 32'h0);

      // R2 output word and driver enable
      apb_wr(8'h88, 32'hA5A5_A5A5);
      apb_rd(8'h88, rd); chk("R2 dout readback", rd, 32'hA5A5_A5A5);
      chk("R2 pad_out", pad_out, 32'hA5A5_A5A5);
      apb_wr(8'h0C, 32'h01);
      chk("R2 oe needs driver bit", pad_oe, 32'h0);
      apb_wr(8'h0C, 32'h05);
      chk("R2 oe pin3", pad_oe, 32'h0000_0008);
      apb_wr(8'h0C, 32'h04);
      chk("R2 oe needs output bit", pad_oe, 32'h0);
      apb_wr(8'h0C, 32'h0);

      // R3 synchronized input word
      @(negedge clk);
      pad_in = 32'h3C0F_1234;
      apb_rd(8'h84, rd); chk("R3 input word", rd, 32'h3C0F_1234);
      pad_in = 32'hC3F0_EDCB;
      idle(3);
      apb_rd(8'h84, rd); chk("R3 input word 2", rd, 32'hC3F0_EDCB);
      pad_in = '0;
      idle(4);

      // R5 R6 trigger kinds, one table
      for (int v = 0; v < NV; v++) begin
         int pin;
         logic [2:0] kind;
         pin  = (v * 3 + 1) % NP;
         kind = VEC[v][5:3];
         apb_wr(8'(pin * 4), 32'h02);
         pad_in[pin] = VEC[v][2];
         idle(4);
         apb_wr(8'(pin * 4), {24'b0, kind, 5'b01010});
         apb_wr(8'h80, 32'hFFFF_FFFF);
         @(negedge clk);
         pad_in[pin] = VEC[v][1];
         idle(5);
         apb_rd(8'h80, rd);
         chk($sformatf("R5/R6 vec%0d pend", v), rd, VEC[v][0] ? (32'h1 << pin) : 32'h0);
         chk($sformatf("R9 vec%0d irq", v), {31'b0, irq}, {31'b0, VEC[v][0]});
         apb_wr(8'(pin * 4), 32'h0);
         pad_in = '0;
         idle(4);
         apb_wr(8'h80, 32'hFFFF_FFFF);
      end

      // R4 event enabled but input path off
      apb_wr(8'h1C, 32'h08);
      pad_in[7] = 1'b1;
      idle(5);
      apb_rd(8'h80, rd); chk("R4 gated by input enable", rd, 32'h0);
      chk("R4 irq quiet", {31'b0, irq}, 32'd0);
      apb_wr(8'h1C, 32'h0);
      pad_in[7] = 1'b0;
      idle(4);

      // R8 persistent level re-pends; R7 zero write ignored
      apb_wr(8'h24, 32'h0A);
      pad_in[9] = 1'b1;
      idle(5);
      apb_rd(8'h80, rd); chk("R5 level high pend", rd, 32'h0000_0200);
      apb_wr(8'h80, 32'h0000_0200);
      apb_rd(8'h80, rd); chk("R8 level re-pends", rd, 32'h0000_0200);
      apb_wr(8'h80, 32'h0);
      apb_rd(8'h80, rd); chk("R7 zero write", rd, 32'h0000_0200);
      pad_in[9] = 1'b0;
      idle(4);
      apb_wr(8'h80, 32'h0000_0200);
      apb_rd(8'h80, rd); chk("R7 clear after level gone", rd, 32'h0);
      apb_wr(8'h24, 32'h0);

      // R7 edge flag clear
      apb_wr(8'h2C, 32'h4A);
      @(negedge clk); pad_in[11] = 1'b1;
      idle(5);
      apb_wr(8'h80, 32'hFFFF_F7FF);
      apb_rd(8'h80, rd); chk("R7 other ones keep flag", rd, 32'h0000_0800);
      apb_wr(8'h80, 32'h0000_0800);
      apb_rd(8'h80, rd); chk("R7 edge flag cleared", rd, 32'h0);
      chk("R9 irq after clear", {31'b0, irq}, 32'd0);
      apb_wr(8'h2C, 32'h0);
      pad_in[11] = 1'b0;

      // R9 two sources
      apb_wr(8'h30, 32'h4A);
      apb_wr(8'h34, 32'h4A);
      @(negedge clk); pad_in[13:12] = 2'b11;
      idle(5);
      apb_rd(8'h80, rd); chk("R9 two flags", rd, 32'h0000_3000);
      apb_wr(8'h80, 32'h0000_1000);
      chk("R9 irq one left", {31'b0, irq}, 32'd1);
      apb_wr(8'h80, 32'h0000_2000);
      chk("R9 irq none left", {31'b0, irq}, 32'd0);
      apb_wr(8'h30, 32'h0);
      apb_wr(8'h34, 32'h0);
      pad_in = '0;

      // R10 unmapped offsets
      apb_rd(8'h8C, rd); chk("R10 0x8C", rd, 32'h0);
      apb_rd(8'h90, rd); chk("R10 0x90", rd, 32'h0);
      apb_rd(8'hFC, rd); chk("R10 0xFC", rd, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule